// File: doc/BRIEF.md
# ADC Serial-Port Slave

This block is the converter-side end of a three- or four-wire serial link. It lets a host controller reach three 24-bit registers: configuration, gain and conversion data. It also lets the host start calibrations and conversions on a converter core, which sits outside the block and is represented here only by a start/done handshake. The host frames each access with a command byte, sent most significant bit first on `sdi` while `cs_n` is low. A write command is followed by three data bytes. A read command makes the port drive three bytes back on `sdo`. After either transfer the port returns to waiting for the next command.

The host can always get back into step. It sends at least fifteen consecutive 0xFF bytes and then any byte whose least significant bit is 0. This puts the port in the command-wait state no matter where it was.

When the port-flag bit of the configuration register is set, `sdo` serves as a conversion-complete signal. It idles high and drops low when a requested conversion finishes. The host then gives 8 clocks to clear the flag, followed by 24 clocks that carry the result.

All serial inputs must already be synchronous to `clk`. `sclk` is sampled by `clk`, and each of its high and low phases must last at least two `clk` cycles. Data on `sdi` is taken on the rising `sclk` edge. Data on `sdo` is valid from one `clk` cycle after a rising edge until the next rising edge.

Top module: `adc_serial_port`

## Requirements
- R1: Command byte codes are as follows. 0x80|r writes register r and 0xC0|r reads register r, where r=0 is configuration, r=1 is gain and r=2 is conversion data. 0x0C starts a conversion. Any other byte, including r=3 or any of bits 5..2 set, is ignored and the port stays waiting for a command.
- R2: A write takes the next 24 `sdi` bits, most significant bit first, and stores them after the last bit. Writes to the data register have no effect. Configuration bit 3 cannot be changed by a write.
- R3: A read drives the selected register on `sdo`, most significant bit first, for 24 rising `sclk` edges. The port then waits for a command again.
- R4: The resync pattern returns the port to command-wait from any state, and the terminating byte is consumed. The pattern is at least 15 consecutive 0xFF bytes followed by a byte with bit 0 equal to 0. With only 14 0xFF bytes, the final byte is decoded as an ordinary command.
- R5: Raising `cs_n` resets the bit position within the byte to zero. The next byte after `cs_n` falls is aligned to the first rising edge.
- R6: Command 0x0C raises `conv_start` for exactly one cycle. The next `done` pulse loads `result` into the data register and sets configuration bit 3 (done flag).
- R7: A configuration write with bit 0 set raises `cal_start` for one cycle. Bit 0 reads as 1 until `done` arrives. At that point bit 0 clears and bit 3 is set.
- R8: A configuration read returns the done flag as it stood and then clears it.
- R9: With configuration bit 4 (port flag) at 0, `sdo` is low whenever no read is shifting out.
- R10: With bit 4 at 1, `sdo` is high while idle and goes low within two cycles of the `done` that completes a requested conversion. The next 8 `sclk` edges clear the flag while `sdo` stays low and `sdi` is ignored. The following 24 edges carry the result, most significant bit first. Afterwards `sdo` returns high.
- R11: After reset the configuration register is 0, gain is 0x800000, data is 0, `sdo` is low and the port is waiting for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Port select, active low |
| sclk | input | 1 | Serial bit clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data / conversion-complete flag to host |
| done | input | 1 | One-cycle completion strobe from converter core |
| result | input | 24 | Conversion result, valid with `done` |
| cal_start | output | 1 | One-cycle request for self-offset calibration |
| conv_start | output | 1 | One-cycle request for a single conversion |

## Verification
Most internal faults show up on `sdo` within the next byte. A port stuck in the wrong state, or out of byte alignment, turns the following read into shifted or zero data. A wrongly held port flag shows up directly as the idle level of `sdo`. A resync counter with the wrong threshold shows up in the byte right after the terminator: that byte either starts a stray read or fails to. Done-flag faults appear on the very next configuration read, and a second read shows whether the clear-on-read took effect.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        ST_CMD = 2'd0,
        ST_WR  = 2'd1,
        ST_RD  = 2'd2
    } sp_state_e;

    localparam logic [1:0] REG_CFG  = 2'd0;
    localparam logic [1:0] REG_GAIN = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;
    localparam logic [1:0] REG_NONE = 2'd3;

    localparam logic [7:0] OP_CONVERT = 8'h0C;

    localparam int CFG_CAL_BIT  = 0;
    localparam int CFG_DONE_BIT = 3;
    localparam int CFG_PF_BIT   = 4;

endpackage

// File: rtl/sp_edge.sv
module sp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic rise
);
    logic sclk_d, sclk_q;

    always_comb begin
        sclk_d = sclk;
        rise   = sclk && !sclk_q && !cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end
endmodule

// File: rtl/sp_resync.sv
module sp_resync #(
    parameter int RESYNC_MIN = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rise,
    input  logic       sdi,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       resync
);
    localparam int CW = $clog2(RESYNC_MIN + 1);

    typedef struct packed {
        logic [2:0]    bcnt;
        logic [6:0]    shr;
        logic [CW-1:0] ones;
    } rs_t;

    rs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        byte_val  = {st_q.shr, sdi};
        byte_done = rise && (st_q.bcnt == 3'd7);
        resync    = byte_done && (st_q.ones >= CW'(RESYNC_MIN)) && !sdi;
        if (cs_n) begin
            st_d.bcnt = '0;
        end else if (rise) begin
            st_d.bcnt = st_q.bcnt + 3'd1;
            st_d.shr  = {st_q.shr[5:0], sdi};
            if (byte_done) begin
                if (byte_val == 8'hFF) begin
                    if (st_q.ones < CW'(RESYNC_MIN))
                        st_d.ones = st_q.ones + CW'(1);
                end else begin
                    st_d.ones = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sp_regfile.sv
module sp_regfile
    import adc_sp_pkg::*;
#(
    parameter int             DW       = 24,
    parameter logic [DW-1:0]  GAIN_RST = 24'h800000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_take,
    input  logic          conv_cmd,
    input  logic          flag_clr,
    input  logic          done,
    input  logic [DW-1:0] result,
    output logic [DW-1:0] rd_data,
    output logic          pf,
    output logic          flag,
    output logic          cal_start,
    output logic          conv_start
);
    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] gain;
        logic [DW-1:0] data;
        logic          conv_pend;
        logic          flag;
        logic          cal_start;
        logic          conv_start;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.cal_start  = 1'b0;
        st_d.conv_start = 1'b0;

        if (rd_take && addr == REG_CFG)
            st_d.cfg[CFG_DONE_BIT] = 1'b0;

        if (wr_en) begin
            case (addr)
                REG_CFG: begin
                    st_d.cfg               = wr_data;
                    st_d.cfg[CFG_DONE_BIT] = st_q.cfg[CFG_DONE_BIT];
                    if (wr_data[CFG_CAL_BIT]) st_d.cal_start = 1'b1;
                end
                REG_GAIN: st_d.gain = wr_data;
                default: ;
            endcase
        end

        if (conv_cmd) begin
            st_d.conv_pend  = 1'b1;
            st_d.conv_start = 1'b1;
        end

        if (flag_clr) st_d.flag = 1'b0;

        if (done) begin
            st_d.cfg[CFG_DONE_BIT] = 1'b1;
            st_d.cfg[CFG_CAL_BIT]  = 1'b0;
            if (st_q.conv_pend) begin
                st_d.data      = result;
                st_d.conv_pend = 1'b0;
                if (st_q.cfg[CFG_PF_BIT]) st_d.flag = 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            REG_CFG:  rd_data = st_q.cfg;
            REG_GAIN: rd_data = st_q.gain;
            REG_DATA: rd_data = st_q.data;
            default:  rd_data = '0;
        endcase
        pf         = st_q.cfg[CFG_PF_BIT];
        flag       = st_q.flag;
        cal_start  = st_q.cal_start;
        conv_start = st_q.conv_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.gain <= GAIN_RST;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int            DW         = 24,
    parameter int            RESYNC_MIN = 15,
    parameter logic [DW-1:0] GAIN_RST   = 24'h800000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          sdi,
    output logic          sdo,
    input  logic          done,
    input  logic [DW-1:0] result,
    output logic          cal_start,
    output logic          conv_start
);
    localparam int NBYTES = DW / 8;
    localparam int BIW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        sp_state_e      state;
        logic [1:0]     addr;
        logic [BIW-1:0] bidx;
        logic [DW-1:0]  sh;
    } port_t;

    port_t st_d, st_q;

    logic          rise, byte_done, resync;
    logic [7:0]    byte_val;
    logic [1:0]    rf_addr;
    logic          wr_en, rd_take, conv_cmd, flag_clr;
    logic [DW-1:0] wr_data, rd_data;
    logic          pf, flag;
    sp_state_e     st_cur;

    sp_edge i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .cs_n (cs_n),
        .sclk (sclk),
        .rise (rise)
    );

    sp_resync #(.RESYNC_MIN(RESYNC_MIN)) i_resync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rise     (rise),
        .sdi      (sdi),
        .byte_done(byte_done),
        .byte_val (byte_val),
        .resync   (resync)
    );

    sp_regfile #(.DW(DW), .GAIN_RST(GAIN_RST)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (rf_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_take   (rd_take),
        .conv_cmd  (conv_cmd),
        .flag_clr  (flag_clr),
        .done      (done),
        .result    (result),
        .rd_data   (rd_data),
        .pf        (pf),
        .flag      (flag),
        .cal_start (cal_start),
        .conv_start(conv_start)
    );

    assign st_cur = st_q.state;

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        rd_take  = 1'b0;
        conv_cmd = 1'b0;
        flag_clr = 1'b0;
        wr_data  = {st_q.sh[DW-2:0], sdi};

        if (st_q.state != ST_CMD) rf_addr = st_q.addr;
        else if (flag)            rf_addr = REG_DATA;
        else                      rf_addr = byte_val[1:0];

        if (rise) begin
            case (st_q.state)
                ST_WR:   st_d.sh = {st_q.sh[DW-2:0], sdi};
                ST_RD:   st_d.sh = {st_q.sh[DW-2:0], 1'b0};
                default: ;
            endcase
        end

        if (byte_done) begin
            if (resync) begin
                st_d.state = ST_CMD;
                st_d.bidx  = '0;
            end else begin
                case (st_q.state)
                    ST_CMD: begin
                        st_d.bidx = '0;
                        if (flag) begin
                            flag_clr   = 1'b1;
                            st_d.addr  = REG_DATA;
                            st_d.sh    = rd_data;
                            st_d.state = ST_RD;
                        end else if (byte_val == OP_CONVERT) begin
                            conv_cmd = 1'b1;
                        end else if (byte_val[7] && byte_val[5:2] == 4'd0 &&
                                     byte_val[1:0] != REG_NONE) begin
                            st_d.addr = byte_val[1:0];
                            if (byte_val[6]) begin
                                rd_take    = 1'b1;
                                st_d.sh    = rd_data;
                                st_d.state = ST_RD;
                            end else begin
                                st_d.state = ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (st_q.bidx == BIW'(NBYTES - 1)) begin
                            wr_en      = 1'b1;
                            st_d.state = ST_CMD;
                        end else begin
                            st_d.bidx = st_q.bidx + BIW'(1);
                        end
                    end
                    ST_RD: begin
                        if (st_q.bidx == BIW'(NBYTES - 1)) st_d.state = ST_CMD;
                        else                               st_d.bidx  = st_q.bidx + BIW'(1);
                    end
                    default: st_d.state = ST_CMD;
                endcase
            end
        end

        if (st_cur == ST_RD) sdo = st_q.sh[DW-1];
        else                 sdo = pf && !flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_CMD;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sp_checker.sv
module sp_checker
    import adc_sp_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input logic      sdo,
    input logic      rise,
    input logic      resync,
    input sp_state_e state,
    input logic      pf,
    input logic      flag,
    input logic      cal_start,
    input logic      conv_start
);
    assert_sdo_low_flag_mode_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf && state != ST_RD) |-> !sdo);

    assert_flag_drives_sdo_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && state == ST_CMD) |-> !sdo);

    assert_resync_lands_in_command_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> state == ST_CMD);

    assert_conv_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_cal_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    assert_read_bit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD && !rise) |=> $stable(sdo));

    assert_deselect_freezes_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && state == ST_RD) |=> $stable(sdo));
endmodule

bind adc_serial_port sp_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo       (sdo),
    .rise      (rise),
    .resync    (resync),
    .state     (st_cur),
    .pf        (pf),
    .flag      (flag),
    .cal_start (cal_start),
    .conv_start(conv_start)
);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        done = 1'b0;
    logic [23:0] result = '0;
    logic        cal_start, conv_start;

    int n_chk = 0;
    int n_fail = 0;
    int n_conv = 0;
    int n_cal = 0;

    always #2.5 clk = ~clk;

    adc_serial_port i_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .done(done), .result(result),
        .cal_start(cal_start), .conv_start(conv_start)
    );

    always @(posedge clk) begin
        if (conv_start) n_conv++;
        if (cal_start)  n_cal++;
    end

    // entry: {register code, value written, value expected on readback}
    localparam logic [49:0] VEC [0:5] = '{
        {2'd1, 24'h123456, 24'h123456},
        {2'd1, 24'hA5A5A5, 24'hA5A5A5},
        {2'd1, 24'hFFFFFF, 24'hFFFFFF},
        {2'd0, 24'h000440, 24'h000440},
        {2'd0, 24'h000008, 24'h000000},
        {2'd2, 24'h777777, 24'h000000}
    };

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            sdi = tx[i];
            repeat (3) @(negedge clk);
            rx[i] = sdo;
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
        sbits(tx, 8, rx);
    endtask

    task automatic put(input logic [7:0] tx);
        logic [7:0] rx;
        sbyte(tx, rx);
    endtask

    task automatic rd24(output logic [23:0] v);
        logic [7:0] b2, b1, b0;
        sbyte(8'h00, b2);
        sbyte(8'h00, b1);
        sbyte(8'h00, b0);
        v = {b2, b1, b0};
    endtask

    task automatic wr_reg(input logic [1:0] r, input logic [23:0] val);
        put({6'b100000, r});
        put(val[23:16]);
        put(val[15:8]);
        put(val[7:0]);
    endtask

    task automatic rd_reg(input logic [1:0] r, output logic [23:0] v);
        put({6'b110000, r});
        rd24(v);
    endtask

    task automatic pulse_done(input logic [23:0] val);
        @(negedge clk);
        done = 1'b1;
        result = val;
        @(negedge clk);
        done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] v;
        logic [7:0]  b;
        int c0;

        repeat (5) @(negedge clk);
        chk("R11 sdo in reset", {23'd0, sdo}, 24'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 sdo after reset", {23'd0, sdo}, 24'd0);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);

        rd_reg(2'd1, v); chk("R11 gain reset", v, 24'h800000);
        rd_reg(2'd0, v); chk("R11 config reset", v, 24'h000000);
        rd_reg(2'd2, v); chk("R11 data reset", v, 24'h000000);

        // R1 R2 R3: write then read back per table entry
        for (int k = 0; k < 6; k++) begin
            wr_reg(VEC[k][49:48], VEC[k][47:24]);
            rd_reg(VEC[k][49:48], v);
            chk("R2 R3 table write/read", v, VEC[k][23:0]);
        end
        chk("R7 no calibration from table", n_cal, 24'd0);

        // R1: invalid command bytes are ignored
        put(8'h83);
        put(8'h84);
        rd_reg(2'd1, v); chk("R1 invalid commands ignored", v, 24'hFFFFFF);

        // R6: conversion request and completion
        put(8'h0C);
        repeat (3) @(negedge clk);
        chk("R6 conv_start pulse count", n_conv, 24'd1);
        pulse_done(24'hABCDEF);
        rd_reg(2'd0, v); chk("R6 R8 done flag set", v, 24'h000008);
        rd_reg(2'd0, v); chk("R8 done flag cleared by read", v, 24'h000000);
        rd_reg(2'd2, v); chk("R6 result in data register", v, 24'hABCDEF);

        // R7: calibration request
        wr_reg(2'd0, 24'h000001);
        repeat (3) @(negedge clk);
        chk("R7 cal_start pulse count", n_cal, 24'd1);
        rd_reg(2'd0, v); chk("R7 cal bit pending", v, 24'h000001);
        pulse_done(24'h111111);
        rd_reg(2'd0, v); chk("R7 cal done", v, 24'h000008);
        rd_reg(2'd2, v); chk("R7 data untouched by cal", v, 24'hABCDEF);

        // R10: port-flag mode
        wr_reg(2'd0, 24'h000010);
        repeat (3) @(negedge clk);
        chk("R10 sdo idle high", {23'd0, sdo}, 24'd1);
        put(8'h0C);
        repeat (4) @(negedge clk);
        chk("R10 sdo high before done", {23'd0, sdo}, 24'd1);
        pulse_done(24'h13579B);
        @(negedge clk);
        chk("R10 sdo low after done", {23'd0, sdo}, 24'd0);
        sbyte(8'hFF, b);
        chk("R10 flag-clear phase sdo low", {16'd0, b}, 24'd0);
        rd24(v); chk("R10 result after flag clear", v, 24'h13579B);
        repeat (3) @(negedge clk);
        chk("R10 sdo high again", {23'd0, sdo}, 24'd1);

        wr_reg(2'd0, 24'h000000);
        repeat (3) @(negedge clk);
        chk("R9 sdo low with flag mode off", {23'd0, sdo}, 24'd0);

        // R4: resync from inside a read, 15 ones bytes
        wr_reg(2'd1, 24'h2468AC);
        put(8'hC1);
        for (int k = 0; k < 15; k++) put(8'hFF);
        put(8'hC2);
        rd_reg(2'd1, v); chk("R4 resync terminator consumed", v, 24'h2468AC);

        // R4: only 14 ones bytes, terminator decoded as read of data
        for (int k = 0; k < 14; k++) put(8'hFF);
        put(8'hC2);
        rd24(v); chk("R4 short pattern decodes normally", v, 24'h13579B);

        // R5: partial byte then deselect realigns the bit counter
        sbits(8'hF0, 4, b);
        @(negedge clk); cs_n = 1'b1;
        repeat (4) @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        rd_reg(2'd1, v); chk("R5 alignment after cs_n high", v, 24'h2468AC);

        c0 = n_conv;
        chk("R6 no extra conv_start", c0, 24'd2);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule